// File: doc/BRIEF.md
# Codec Response Ring Writer and Dispatcher

This block sits between the link receiver of an audio codec controller and system memory. Each response from a codec arrives as a 32-bit payload plus a 32-bit extended word. The block stores the pair as one 8-byte slot of a circular ring in memory and advances a hardware write pointer. It raises an interrupt once a programmed number of new slots have been written since the last interrupt.

Alongside the ring, the block sorts each accepted response. The low nibble of the extended word names the codec, and one flag bit marks an unsolicited event. Events go out on their own strobe. Solicited replies are matched against a per-codec count of commands still waiting for an answer. The command path raises that count with a one-cycle pulse and an address. A reply to a waiting codec stores the payload as that codec's latest result and lowers the count. When the count reaches zero, the codec's completion flag is raised. A reply that nothing was waiting for is flagged as spurious, and an address outside the codec range is flagged as an error.

Top module: `resp_ring_dispatch`

## Requirements
- R1: After reset the write pointer is 0, no memory write is issued, the interrupt is low, every outstanding count is 0 (all completion flags high) and every latest result is 0.
- R2: A response accepted in cycle t gives, at the next edge, one 64-bit memory write. Its byte address is cmd_base + 2048 + 8 × p, where p = (old pointer + 1) mod 256. The payload goes in bits 31:0 and the extended word in bits 63:32. wr_ptr becomes p, so it wraps from 255 to 0.
- R3: While dma_en is low, a response is ignored: no write, no pointer change, no event, no count change.
- R4: A wp_rst pulse sets the write pointer to 0 and clears the interrupt slot count. A response offered in the same cycle is dropped.
- R5: The interrupt status bit is set when the number of slots written since it was last set reaches irq_thresh, where 0 means 256. irq equals status AND irq_en. An irq_clr pulse clears the status, and setting wins over clearing in the same cycle.
- R6: An accepted response whose extended bit 4 is 1 and whose address is valid produces a one-cycle unsol_valid with its payload and extended word. It changes no count.
- R7: A cmd_issued pulse raises the outstanding count of codec cmd_addr by one, saturating at 255. codec_done[i] is high exactly when the count of codec i is 0.
- R8: A solicited response (bit 4 = 0) for a codec whose count is nonzero updates that codec's latest result to the payload and lowers its count by one.
- R9: A solicited response for a codec whose count is 0 gives a one-cycle spurious pulse and leaves the latest result and the count unchanged.
- R10: An extended-word address (bits 3:0) at or above NUM_CODECS gives a one-cycle addr_err pulse. No event or count change follows, though the slot is still written.
- R11: A command pulse and a solicited response for the same codec in one cycle are judged against the count before the command. A waiting codec keeps its count. An idle codec reports spurious and ends with a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_en | input | 1 | Ring writing enable |
| irq_en | input | 1 | Interrupt output enable |
| wp_rst | input | 1 | Pulse: clear write pointer |
| irq_clr | input | 1 | Pulse: write-1-to-clear of interrupt status |
| irq_thresh | input | 8 | Slots per interrupt, 0 means 256 |
| cmd_base | input | 64 | Byte base of the command ring |
| rsp_valid | input | 1 | Response strobe |
| rsp_data | input | 32 | Response payload |
| rsp_ext | input | 32 | Extended word: bits 3:0 codec, bit 4 unsolicited |
| cmd_issued | input | 1 | Pulse: a command was sent |
| cmd_addr | input | 4 | Codec of the sent command |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 64 | Byte address of the slot |
| mem_wr_data | output | 64 | {extended, payload} |
| wr_ptr | output | 8 | Hardware write pointer |
| irq | output | 1 | Response interrupt |
| codec_done | output | NUM_CODECS | Count is zero, per codec |
| codec_last | output | 32×NUM_CODECS | Latest solicited payload, codec i at bits 32i+31:32i |
| unsol_valid | output | 1 | Unsolicited event strobe |
| unsol_data | output | 32 | Event payload |
| unsol_ext | output | 32 | Event extended word |
| spurious | output | 1 | Unexpected solicited response |
| addr_err | output | 1 | Codec address out of range |

## Verification
Directed sequences set apart the four outcomes of a response: matched, spurious, unsolicited and out-of-range address. Each of these must leave the counts and latest results it should not touch unchanged. Pulses that meet in one cycle separate the priorities: command with response, pointer reset with response, and status set with clear. A long random stretch drives more than 256 slots with mixed addresses and flags. It covers pointer wrap and the 256-slot interrupt threshold, and every cycle it is compared against a behavioural model.

// File: rtl/rr_pkg.sv
// Shared constants and types for the response ring dispatcher.
// Assumes the extended word carries the codec address in its low nibble
// and the unsolicited flag in bit 4; the block decodes both.
package rr_pkg;
    localparam int CODEC_AW    = 4;
    localparam int UNSOL_BIT   = 4;
    localparam int WORD_W      = 32;

    typedef struct packed {
        logic [WORD_W-1:0] ext;
        logic [WORD_W-1:0] data;
    } rr_entry_t;

    typedef enum logic [1:0] {
        RSP_SOLICITED = 2'd0,
        RSP_UNSOL     = 2'd1,
        RSP_BAD_ADDR  = 2'd2
    } rsp_kind_t;
endpackage

// File: rtl/rr_ring_writer.sv
// Ring writer: turns each accepted response into one slot write,
// pre-incrementing the write pointer, and counts slots toward the
// interrupt threshold. Assumes RING_ENTRIES is a power of two so the
// pointer wraps by natural overflow.
module rr_ring_writer
    import rr_pkg::*;
#(
    parameter int ADDR_W       = 64,
    parameter int RING_ENTRIES = 256,
    parameter int RING_OFFSET  = 2048,
    parameter int ENTRY_BYTES  = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               store,
    input  logic                               wp_rst,
    input  logic                               irq_en,
    input  logic                               irq_clr,
    input  logic [$clog2(RING_ENTRIES)-1:0]    irq_thresh,
    input  logic [ADDR_W-1:0]                  cmd_base,
    input  rr_entry_t                          entry,
    output logic                               mem_wr_en,
    output logic [ADDR_W-1:0]                  mem_wr_addr,
    output logic [2*WORD_W-1:0]                mem_wr_data,
    output logic [$clog2(RING_ENTRIES)-1:0]    wr_ptr,
    output logic                               irq
);
    localparam int PTR_W     = $clog2(RING_ENTRIES);
    localparam int CNT_W     = PTR_W + 1;
    localparam int SLOT_SH   = $clog2(ENTRY_BYTES);

    logic [PTR_W-1:0] next_ptr;
    logic [CNT_W-1:0] slot_cnt;
    logic [CNT_W-1:0] thresh_eff;
    logic [CNT_W-1:0] slot_cnt_inc;
    logic             thresh_hit;
    logic             irq_stat;

    // Next pointer and threshold decode.
    always_comb begin
        next_ptr     = wr_ptr + 1'b1;
        thresh_eff   = (irq_thresh == '0) ? CNT_W'(RING_ENTRIES) : {1'b0, irq_thresh};
        slot_cnt_inc = slot_cnt + 1'b1;
        thresh_hit   = store && (slot_cnt_inc >= thresh_eff);
    end

    // Write pointer: reset pulse clears, stores pre-increment.
    always_ff @(posedge clk) begin
        if (!rst_n || wp_rst) wr_ptr <= '0;
        else if (store)       wr_ptr <= next_ptr;
    end

    // Memory write port registered one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr_en   <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
        end else begin
            mem_wr_en <= store;
            if (store) begin
                mem_wr_addr <= cmd_base + ADDR_W'(RING_OFFSET)
                             + (ADDR_W'(next_ptr) << SLOT_SH);
                mem_wr_data <= entry;
            end
        end
    end

    // Slots written since the interrupt status was last set.
    always_ff @(posedge clk) begin
        if (!rst_n || wp_rst) slot_cnt <= '0;
        else if (thresh_hit)  slot_cnt <= '0;
        else if (store)       slot_cnt <= slot_cnt_inc;
    end

    // Interrupt status: set wins over write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_stat <= 1'b0;
        else if (thresh_hit) irq_stat <= 1'b1;
        else if (irq_clr)    irq_stat <= 1'b0;
    end

    assign irq = irq_stat & irq_en;

    // Every slot write moves the pointer by exactly one.
    assert_wp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)));

    // Status only rises together with a slot write.
    assert_irq_has_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat) |-> mem_wr_en);

    // A pointer reset leaves the pointer at zero and writes nothing.
    assert_wp_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wp_rst |=> (wr_ptr == '0) && !mem_wr_en);
endmodule

// File: rtl/rr_classifier.sv
// Classifier: decodes the extended word of an accepted response into
// matched, spurious, unsolicited or bad-address outcomes. Assumes the
// per-codec idle flags reflect counts before this cycle's update.
module rr_classifier
    import rr_pkg::*;
#(
    parameter int NUM_CODECS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  rr_entry_t             entry,
    input  logic [NUM_CODECS-1:0] idle,
    output logic [NUM_CODECS-1:0] dec_vec,
    output logic                  unsol_valid,
    output logic [WORD_W-1:0]     unsol_data,
    output logic [WORD_W-1:0]     unsol_ext,
    output logic                  spurious,
    output logic                  addr_err
);
    logic [CODEC_AW-1:0]   codec;
    logic [NUM_CODECS-1:0] sel;
    rsp_kind_t             kind;
    logic                  sel_idle;
    logic                  is_sol;

    // Decode the responding codec into a one-hot select.
    always_comb begin
        codec = entry.ext[CODEC_AW-1:0];
        for (int i = 0; i < NUM_CODECS; i++) sel[i] = (32'(codec) == i);
        sel_idle = |(sel & idle);
    end

    // Kind of response; an invalid address takes precedence.
    always_comb begin
        if (32'(codec) >= NUM_CODECS)   kind = RSP_BAD_ADDR;
        else if (entry.ext[UNSOL_BIT])  kind = RSP_UNSOL;
        else                            kind = RSP_SOLICITED;
        is_sol  = accept && (kind == RSP_SOLICITED);
        dec_vec = (is_sol && !sel_idle) ? sel : '0;
    end

    // Registered event strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unsol_valid <= 1'b0;
            unsol_data  <= '0;
            unsol_ext   <= '0;
            spurious    <= 1'b0;
            addr_err    <= 1'b0;
        end else begin
            unsol_valid <= accept && (kind == RSP_UNSOL);
            spurious    <= is_sol && sel_idle;
            addr_err    <= accept && (kind == RSP_BAD_ADDR);
            if (accept && (kind == RSP_UNSOL)) begin
                unsol_data <= entry.data;
                unsol_ext  <= entry.ext;
            end
        end
    end

    // At most one outcome is reported per response.
    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({unsol_valid, spurious, addr_err}));

    // Only a waiting codec is ever decremented.
    assert_dec_waiting_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_vec) && ((dec_vec & idle) == '0));
endmodule

// File: rtl/rr_codec_slot.sv
// One codec's outstanding-command counter and latest solicited result.
// Assumes inc and dec may arrive together; they then cancel.
module rr_codec_slot
    import rr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    input  logic [WORD_W-1:0] data,
    output logic              idle,
    output logic [WORD_W-1:0] last
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;

    // Outstanding count, saturating on increment.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else begin
            unique case ({inc, dec})
                2'b10:   if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Latest result of a matched response.
    always_ff @(posedge clk) begin
        if (!rst_n)   last <= '0;
        else if (dec) last <= data;
    end

    assign idle = (cnt == '0);

    // An idle codec stays idle unless a command is issued.
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !inc) |=> idle);

    // A command to an idle codec always leaves it waiting.
    assert_cmd_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && inc) |=> !idle);
endmodule

// File: rtl/rr_codec_tracker.sv
// Bank of per-codec slots; routes command pulses by address and
// flattens the latest results. Addresses outside the bank are ignored.
module rr_codec_tracker
    import rr_pkg::*;
#(
    parameter int NUM_CODECS = 16,
    parameter int CNT_W      = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_issued,
    input  logic [CODEC_AW-1:0]          cmd_addr,
    input  logic [NUM_CODECS-1:0]        dec_vec,
    input  logic [WORD_W-1:0]            data,
    output logic [NUM_CODECS-1:0]        idle,
    output logic [NUM_CODECS*WORD_W-1:0] last_flat
);
    logic [NUM_CODECS-1:0] inc_vec;

    // Decode command pulses into per-codec increments.
    always_comb begin
        for (int i = 0; i < NUM_CODECS; i++)
            inc_vec[i] = cmd_issued && (32'(cmd_addr) == i);
    end

    for (genvar g = 0; g < NUM_CODECS; g++) begin : g_slot
        rr_codec_slot #(.CNT_W(CNT_W)) u_slot (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (inc_vec[g]),
            .dec  (dec_vec[g]),
            .data (data),
            .idle (idle[g]),
            .last (last_flat[g*WORD_W +: WORD_W])
        );
    end
endmodule

// File: rtl/resp_ring_dispatch.sv
// Top: gates responses by the ring enable and pointer reset, writes them
// into the response ring and dispatches them to the codec tracker.
// Assumes one response and one command pulse at most per cycle.
module resp_ring_dispatch
    import rr_pkg::*;
#(
    parameter int NUM_CODECS   = 16,
    parameter int ADDR_W       = 64,
    parameter int RING_ENTRIES = 256,
    parameter int RING_OFFSET  = 2048,
    parameter int CNT_W        = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                dma_en,
    input  logic                                irq_en,
    input  logic                                wp_rst,
    input  logic                                irq_clr,
    input  logic [$clog2(RING_ENTRIES)-1:0]     irq_thresh,
    input  logic [ADDR_W-1:0]                   cmd_base,
    input  logic                                rsp_valid,
    input  logic [31:0]                         rsp_data,
    input  logic [31:0]                         rsp_ext,
    input  logic                                cmd_issued,
    input  logic [3:0]                          cmd_addr,
    output logic                                mem_wr_en,
    output logic [ADDR_W-1:0]                   mem_wr_addr,
    output logic [63:0]                         mem_wr_data,
    output logic [$clog2(RING_ENTRIES)-1:0]     wr_ptr,
    output logic                                irq,
    output logic [NUM_CODECS-1:0]               codec_done,
    output logic [NUM_CODECS*32-1:0]            codec_last,
    output logic                                unsol_valid,
    output logic [31:0]                         unsol_data,
    output logic [31:0]                         unsol_ext,
    output logic                                spurious,
    output logic                                addr_err
);
    rr_entry_t             entry;
    logic                  accept;
    logic [NUM_CODECS-1:0] dec_vec;
    logic [NUM_CODECS-1:0] idle;

    // Acceptance: ring enabled and no pointer reset this cycle.
    always_comb begin
        entry.data = rsp_data;
        entry.ext  = rsp_ext;
        accept     = rsp_valid && dma_en && !wp_rst;
    end

    rr_ring_writer #(
        .ADDR_W      (ADDR_W),
        .RING_ENTRIES(RING_ENTRIES),
        .RING_OFFSET (RING_OFFSET),
        .ENTRY_BYTES (8)
    ) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .store      (accept),
        .wp_rst     (wp_rst),
        .irq_en     (irq_en),
        .irq_clr    (irq_clr),
        .irq_thresh (irq_thresh),
        .cmd_base   (cmd_base),
        .entry      (entry),
        .mem_wr_en  (mem_wr_en),
        .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data),
        .wr_ptr     (wr_ptr),
        .irq        (irq)
    );

    rr_classifier #(.NUM_CODECS(NUM_CODECS)) u_class (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .entry      (entry),
        .idle       (idle),
        .dec_vec    (dec_vec),
        .unsol_valid(unsol_valid),
        .unsol_data (unsol_data),
        .unsol_ext  (unsol_ext),
        .spurious   (spurious),
        .addr_err   (addr_err)
    );

    rr_codec_tracker #(.NUM_CODECS(NUM_CODECS), .CNT_W(CNT_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_issued(cmd_issued),
        .cmd_addr  (cmd_addr),
        .dec_vec   (dec_vec),
        .data      (rsp_data),
        .idle      (idle),
        .last_flat (codec_last)
    );

    assign codec_done = idle;

    // Nothing reaches memory or the dispatcher while the ring is off.
    assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !mem_wr_en && !unsol_valid && !spurious && !addr_err);

    // Every reported outcome comes with its slot write.
    assert_outcome_written_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (unsol_valid || spurious || addr_err) |-> mem_wr_en);
endmodule

// File: tb/resp_ring_dispatch_tb.sv
module resp_ring_dispatch_tb;
    localparam int NC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_en = 0, irq_en = 0, wp_rst = 0, irq_clr = 0;
    logic [7:0]  irq_thresh = 8'd1;
    logic [63:0] cmd_base = 64'h0000_0000_8000_0000;
    logic rsp_valid = 0;
    logic [31:0] rsp_data = 0, rsp_ext = 0;
    logic cmd_issued = 0;
    logic [3:0] cmd_addr = 0;
    logic mem_wr_en;
    logic [63:0] mem_wr_addr, mem_wr_data;
    logic [7:0] wr_ptr;
    logic irq;
    logic [NC-1:0] codec_done;
    logic [NC*32-1:0] codec_last;
    logic unsol_valid, spurious, addr_err;
    logic [31:0] unsol_data, unsol_ext;

    int total = 0, bad = 0;

    always #4 clk = ~clk;

    resp_ring_dispatch #(.NUM_CODECS(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .irq_en(irq_en),
        .wp_rst(wp_rst), .irq_clr(irq_clr), .irq_thresh(irq_thresh),
        .cmd_base(cmd_base), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_ext(rsp_ext), .cmd_issued(cmd_issued), .cmd_addr(cmd_addr),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .wr_ptr(wr_ptr), .irq(irq), .codec_done(codec_done), .codec_last(codec_last),
        .unsol_valid(unsol_valid), .unsol_data(unsol_data), .unsol_ext(unsol_ext),
        .spurious(spurious), .addr_err(addr_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on each rising edge.
    bit armed = 0;
    int m_wp, m_icnt, m_thr;
    bit m_ist, m_wen, m_unsol, m_spur, m_err, m_acc;
    logic [63:0] m_addr, m_data;
    logic [31:0] m_ud, m_ue;
    int m_cnt [NC];
    logic [31:0] m_last [NC];

    always @(posedge clk) begin
        armed = 1;
        if (!rst_n) begin
            m_wp = 0; m_icnt = 0; m_ist = 0; m_wen = 0; m_unsol = 0;
            m_spur = 0; m_err = 0; m_addr = 0; m_data = 0; m_ud = 0; m_ue = 0;
            foreach (m_cnt[i]) begin m_cnt[i] = 0; m_last[i] = 0; end
        end else begin
            int a, old_cnt;
            bit set_irq;
            m_acc = rsp_valid && dma_en && !wp_rst;
            m_wen = 0; m_unsol = 0; m_spur = 0; m_err = 0; set_irq = 0;
            if (wp_rst) begin m_wp = 0; m_icnt = 0; end
            if (m_acc) begin
                m_wp = (m_wp + 1) % 256;
                m_wen = 1;
                m_addr = cmd_base + 64'd2048 + 64'(8 * m_wp);
                m_data = {rsp_ext, rsp_data};
                m_thr = (irq_thresh == 0) ? 256 : int'(irq_thresh);
                m_icnt++;
                if (m_icnt >= m_thr) begin set_irq = 1; m_icnt = 0; end
            end
            if (set_irq) m_ist = 1;
            else if (irq_clr) m_ist = 0;
            a = int'(rsp_ext[3:0]);
            old_cnt = (a < NC) ? m_cnt[a] : 0;
            if (m_acc) begin
                if (a >= NC) m_err = 1;
                else if (rsp_ext[4]) begin m_unsol = 1; m_ud = rsp_data; m_ue = rsp_ext; end
                else if (old_cnt > 0) begin m_last[a] = rsp_data; m_cnt[a]--; end
                else m_spur = 1;
            end
            if (cmd_issued && int'(cmd_addr) < NC && m_cnt[cmd_addr] < 255)
                m_cnt[cmd_addr]++;
            else if (cmd_issued && int'(cmd_addr) < NC && m_acc && !rsp_ext[4]
                     && a == int'(cmd_addr) && old_cnt == 255)
                m_cnt[cmd_addr]++;
        end
    end

    // Compare every cycle, 2 ns after the edge.
    always @(posedge clk) begin
        #2;
        if (armed) begin
            chk("R2 mem_wr_en", 64'(mem_wr_en), 64'(m_wen));
            if (m_wen) begin
                chk("R2 mem_wr_addr", mem_wr_addr, m_addr);
                chk("R2 mem_wr_data", mem_wr_data, m_data);
            end
            chk("R2 wr_ptr", 64'(wr_ptr), 64'(m_wp));
            chk("R5 irq", 64'(irq), 64'(m_ist && irq_en));
            chk("R6 unsol_valid", 64'(unsol_valid), 64'(m_unsol));
            if (m_unsol) chk("R6 unsol words", {unsol_ext, unsol_data}, {m_ue, m_ud});
            chk("R9 spurious", 64'(spurious), 64'(m_spur));
            chk("R10 addr_err", 64'(addr_err), 64'(m_err));
            for (int i = 0; i < NC; i++) begin
                chk("R7 codec_done", 64'(codec_done[i]), 64'(m_cnt[i] == 0));
                chk("R8 codec_last", 64'(codec_last[i*32 +: 32]), 64'(m_last[i]));
            end
        end
    end

    task automatic tick();
        @(posedge clk); #4;
    endtask

    task automatic send(input logic [31:0] d, input logic [31:0] e);
        rsp_valid = 1; rsp_data = d; rsp_ext = e;
        tick();
        rsp_valid = 0;
    endtask

    task automatic issue(input logic [3:0] a);
        cmd_issued = 1; cmd_addr = a;
        tick();
        cmd_issued = 0;
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] ptr_keep;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 wr_ptr", 64'(wr_ptr), 0);
        chk("R1 irq", 64'(irq), 0);
        chk("R1 done", 64'(codec_done), 64'({NC{1'b1}}));
        chk("R1 no write", 64'(mem_wr_en), 0);

        dma_en = 1; irq_en = 1; irq_thresh = 8'd1;
        // R7 outstanding counts
        issue(4'd2); issue(4'd2); issue(4'd5);
        chk("R7 codec2 waiting", 64'(codec_done[2]), 0);
        // R2 slot layout, R8 matched
        send(32'hAAAA_0001, 32'h2);
        chk("R2 addr", mem_wr_addr, 64'h8000_0808);
        chk("R2 data", mem_wr_data, 64'h0000_0002_AAAA_0001);
        chk("R8 last2", 64'(codec_last[2*32 +: 32]), 64'hAAAA_0001);
        chk("R8 still waiting", 64'(codec_done[2]), 0);
        send(32'hBBBB_0002, 32'h2);
        chk("R8 done2", 64'(codec_done[2]), 1);
        // R9 spurious
        send(32'hCCCC_0003, 32'h7);
        chk("R9 pulse", 64'(spurious), 1);
        chk("R9 last7 kept", 64'(codec_last[7*32 +: 32]), 0);
        // R6 unsolicited
        send(32'hDDDD_0004, 32'h15);
        chk("R6 event", 64'(unsol_valid), 1);
        chk("R6 payload", 64'(unsol_data), 64'hDDDD_0004);
        chk("R6 count kept", 64'(codec_done[5]), 0);
        // R10 address out of range
        send(32'hEEEE_0005, 32'hD);
        chk("R10 err", 64'(addr_err), 1);
        chk("R10 written", 64'(mem_wr_en), 1);
        // R11 simultaneous command and response
        cmd_issued = 1; cmd_addr = 4'd9;
        send(32'h9999_0009, 32'h9);
        cmd_issued = 0;
        chk("R11 spurious", 64'(spurious), 1);
        chk("R11 now waiting", 64'(codec_done[9]), 0);
        cmd_issued = 1; cmd_addr = 4'd5;
        send(32'h5555_0005, 32'h5);
        cmd_issued = 0;
        chk("R11 codec5 kept", 64'(codec_done[5]), 0);
        chk("R11 last5", 64'(codec_last[5*32 +: 32]), 64'h5555_0005);
        // R3 ring disabled
        ptr_keep = wr_ptr;
        dma_en = 0;
        send(32'h1234_0000, 32'h9);
        chk("R3 no write", 64'(mem_wr_en), 0);
        chk("R3 ptr kept", 64'(wr_ptr), 64'(ptr_keep));
        chk("R3 codec9 kept", 64'(codec_done[9]), 0);
        dma_en = 1;
        // R5 threshold and clear
        irq_thresh = 8'd3;
        irq_clr = 1; tick(); irq_clr = 0;
        chk("R5 cleared", 64'(irq), 0);
        send(32'h1, 32'h1F); send(32'h2, 32'h1F);
        chk("R5 below thresh", 64'(irq), 0);
        send(32'h3, 32'h1F);
        chk("R5 at thresh", 64'(irq), 1);
        irq_en = 0; tick();
        chk("R5 gated", 64'(irq), 0);
        irq_en = 1; irq_clr = 1; tick(); irq_clr = 0;
        chk("R5 w1c", 64'(irq), 0);
        // R4 pointer reset drops concurrent response
        wp_rst = 1;
        send(32'h4444_0000, 32'h1);
        wp_rst = 0;
        chk("R4 ptr zero", 64'(wr_ptr), 0);
        chk("R4 dropped", 64'(mem_wr_en), 0);
        // Random stretch: wrap of R2 and 256-slot threshold of R5
        irq_thresh = 8'd0;
        for (int n = 0; n < 420; n++) begin
            rsp_valid  = ($urandom % 8) != 0;
            rsp_data   = $urandom;
            rsp_ext    = {27'($urandom), 1'(($urandom % 4) == 0), 4'($urandom)};
            cmd_issued = ($urandom % 2) != 0;
            cmd_addr   = 4'($urandom);
            irq_clr    = ($urandom % 97) == 0;
            tick();
        end
        rsp_valid = 0; cmd_issued = 0; irq_clr = 0;
        tick(); tick();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule